// File: doc/BRIEF.md
# Layered egress link scheduler

This block decides, once per transmit slot, which traffic source may put a packet on an egress port. Time-synchronisation packets always win. Flow-control packets come next. Below those two fixed layers sit the tunnelled data paths. Each path carries a configured priority group number (0 to 7) and a round-robin weight. The group with the numerically lowest value among those with a request wins the slot. Inside that group, paths take turns, and each path keeps the slot for up to its weight in consecutive grants.

A typical setup puts the control path in group 0 and display traffic in group 1. Two bulk paths share group 2 with weights 2 and 1, and a host-to-host path goes in group 3. Per-path group and weight settings are copied into the scheduler's working registers only in cycles where no grant is being presented. Reconfiguration therefore never lands in the middle of a burst. The grant is registered: requests sampled at a clock edge with the slot enable high produce a one-hot grant and a valid flag just after that edge.

Top module: `link_slot_sched`

## Requirements
- R1: When `slot_en` and `ts_req` are high at an edge, `gnt_ts` is the only grant after that edge, whatever else is requesting.
- R2: When `slot_en` and `fc_req` are high and `ts_req` is low at an edge, `gnt_fc` is the only grant after that edge.
- R3: With neither fixed layer requesting, the grant goes to a requesting path in the group with the smallest number among groups that have a requesting path. Groups without requests are skipped. A path's group is field `i*3 +: 3` of `cfg_prio`.
- R4: Within a group, the path holding the turn is granted again while it requests and has weight left. Otherwise the turn passes to the next requesting path of that group in ascending index order, wrapping past the highest index, and that path starts with its full weight. A path's weight is field `i*4 +: 4` of `cfg_weight`. After reset the scan of every group starts at path 0.
- R5: If the path holding a group's turn has its request low in a slot, it forfeits its remaining weight. On that group's next win the turn moves on.
- R6: A weight of 0 behaves exactly like a weight of 1.
- R7: `cfg_prio` and `cfg_weight` are captured only at edges where `gnt_valid` is low. A captured value first steers the decision at the edge after the capture.
- R8: When `slot_en` is low at an edge, no grant is presented after it and no turn or weight state moves.
- R9: At most one grant bit is high. `gnt_valid` equals the OR of all grant bits. During reset all grants are low.
- R10: A group that requests but loses the slot to a higher layer or group keeps its turn and remaining weight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_en | input | 1 | A transmit slot is offered at this edge |
| ts_req | input | 1 | Time-synchronisation packet waiting |
| fc_req | input | 1 | Flow-control packet waiting |
| path_req | input | NUM_PATHS | Per-path packet waiting |
| cfg_prio | input | NUM_PATHS*PRIO_W | Per-path priority group, path i at bits i*PRIO_W +: PRIO_W |
| cfg_weight | input | NUM_PATHS*WEIGHT_W | Per-path weight, path i at bits i*WEIGHT_W +: WEIGHT_W |
| gnt_ts | output | 1 | Slot granted to time-sync traffic |
| gnt_fc | output | 1 | Slot granted to flow-control traffic |
| gnt_path | output | NUM_PATHS | One-hot path grant |
| gnt_valid | output | 1 | A grant is presented this cycle |

## Verification
Any corrupted turn pointer or weight count inside a group appears at the ports on that group's next win, as the wrong path or the wrong run length in a burst. A bench that drives long same-group bursts catches it within one weight period. A missing forfeit shows up as the dropped path being granted again right after it returns, instead of its neighbour. A configuration captured too early shows up on the very first slot after the change, when a path jumps groups while grants are still streaming.

// File: rtl/lss_pkg.sv
package lss_pkg;

  // Which layer owns the current slot.
  typedef enum logic [1:0] {
    LYR_IDLE  = 2'd0,
    LYR_TSYNC = 2'd1,
    LYR_FCTL  = 2'd2,
    LYR_PATH  = 2'd3
  } layer_e;

  // Weight 0 is served as weight 1.
  function automatic logic [15:0] eff_weight(input logic [15:0] w);
    return (w == 16'd0) ? 16'd1 : w;
  endfunction

endpackage

// File: rtl/lss_group_rr.sv
module lss_group_rr
  import lss_pkg::*;
#(
  parameter int NUM_PATHS = 8,
  parameter int PRIO_W    = 3,
  parameter int WEIGHT_W  = 4,
  parameter int GROUP_ID  = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          slot_en,
  input  logic                          win,
  input  logic [NUM_PATHS-1:0]          path_req,
  input  logic [NUM_PATHS*PRIO_W-1:0]   path_prio,
  input  logic [NUM_PATHS*WEIGHT_W-1:0] path_weight,
  output logic                          grp_req,
  output logic [NUM_PATHS-1:0]          pick
);

  localparam int IDX_W = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1;
  localparam logic [PRIO_W-1:0] MY_GRP = PRIO_W'(GROUP_ID);

  logic [NUM_PATHS-1:0] mreq;
  logic [IDX_W-1:0]     ptr_q, ptr_d, scan_idx, sel_idx;
  logic [WEIGHT_W-1:0]  rem_q, rem_d, scan_raw, scan_eff;
  logic                 ptr_hit, keep, scan_found, state_en;

  // Membership filter: a path belongs here when its group field matches.
  generate
    for (genvar i = 0; i < NUM_PATHS; i++) begin : g_member
      assign mreq[i] = path_req[i] && (path_prio[i*PRIO_W +: PRIO_W] == MY_GRP);
    end
  endgenerate

  assign grp_req = |mreq;
  assign ptr_hit = mreq[ptr_q];
  assign keep    = ptr_hit && (rem_q != '0);

  // Circular scan for the next requesting member after the pointer.
  always_comb begin
    scan_found = 1'b0;
    scan_idx   = ptr_q;
    for (int k = 1; k <= NUM_PATHS; k++) begin
      int t;
      t = int'(ptr_q) + k;
      if (t >= NUM_PATHS) t = t - NUM_PATHS;
      if (!scan_found && mreq[t]) begin
        scan_found = 1'b1;
        scan_idx   = IDX_W'(t);
      end
    end
  end

  always_comb begin
    scan_raw = path_weight[scan_idx*WEIGHT_W +: WEIGHT_W];
    scan_eff = (scan_raw == '0) ? WEIGHT_W'(1) : scan_raw;
  end

  assign sel_idx = keep ? ptr_q : scan_idx;

  always_comb begin
    pick = '0;
    if (grp_req) pick[sel_idx] = 1'b1;
  end

  // Next-state logic.
  always_comb begin
    ptr_d    = ptr_q;
    rem_d    = rem_q;
    state_en = 1'b0;
    if (slot_en) begin
      if (win && grp_req) begin
        state_en = 1'b1;
        if (keep) begin
          rem_d = rem_q - WEIGHT_W'(1);
        end else begin
          ptr_d = scan_idx;
          rem_d = scan_eff - WEIGHT_W'(1);
        end
      end else if (!ptr_hit) begin
        state_en = 1'b1;
        rem_d    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= IDX_W'(NUM_PATHS - 1);
      rem_q <= '0;
    end else if (state_en) begin
      ptr_q <= ptr_d;
      rem_q <= rem_d;
    end
  end

  // R5
  forfeit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && !ptr_hit && !win) |=> (rem_q == '0));

  // R4
  credit_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && win && keep) |=> ($stable(ptr_q) && (rem_q == $past(rem_q) - WEIGHT_W'(1))));

  // R10
  hold_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && !win && ptr_hit) |=> ($stable(ptr_q) && $stable(rem_q)));

  // R8
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_en) |=> ($stable(ptr_q) && $stable(rem_q)));

endmodule

// File: rtl/lss_layer_pick.sv
module lss_layer_pick
  import lss_pkg::*;
#(
  parameter int NUM_GROUPS = 8
) (
  input  logic                  ts_req,
  input  logic                  fc_req,
  input  logic [NUM_GROUPS-1:0] grp_req,
  output layer_e                layer,
  output logic [NUM_GROUPS-1:0] grp_win
);

  logic grp_any;

  // Strict priority among groups: lowest index wins.
  always_comb begin
    grp_win = '0;
    grp_any = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (!grp_any && grp_req[g]) begin
        grp_win[g] = 1'b1;
        grp_any    = 1'b1;
      end
    end
  end

  always_comb begin
    if (ts_req)       layer = LYR_TSYNC;
    else if (fc_req)  layer = LYR_FCTL;
    else if (grp_any) layer = LYR_PATH;
    else              layer = LYR_IDLE;
  end

endmodule

// File: rtl/link_slot_sched.sv
module link_slot_sched
  import lss_pkg::*;
#(
  parameter int NUM_PATHS = 8,
  parameter int PRIO_W    = 3,
  parameter int WEIGHT_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          slot_en,
  input  logic                          ts_req,
  input  logic                          fc_req,
  input  logic [NUM_PATHS-1:0]          path_req,
  input  logic [NUM_PATHS*PRIO_W-1:0]   cfg_prio,
  input  logic [NUM_PATHS*WEIGHT_W-1:0] cfg_weight,
  output logic                          gnt_ts,
  output logic                          gnt_fc,
  output logic [NUM_PATHS-1:0]          gnt_path,
  output logic                          gnt_valid
);

  localparam int NUM_GROUPS = 1 << PRIO_W;

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  logic [NUM_PATHS*PRIO_W-1:0]   prio_q;
  logic [NUM_PATHS*WEIGHT_W-1:0] weight_q;
  logic                          cfg_en;

  logic [NUM_GROUPS-1:0]                grp_req, grp_win, grp_go;
  logic [NUM_GROUPS-1:0][NUM_PATHS-1:0] grp_pick;
  layer_e                               layer;

  logic                 ts_d, fc_d, valid_d;
  logic [NUM_PATHS-1:0] path_d;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // Working configuration: captured only while no grant is presented.
  assign cfg_en = !gnt_valid;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      prio_q   <= '0;
      weight_q <= '0;
    end else if (cfg_en) begin
      prio_q   <= cfg_prio;
      weight_q <= cfg_weight;
    end
  end

  // One path scheduler per priority group.
  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_go[g] = (layer == LYR_PATH) && grp_win[g];
      lss_group_rr #(
        .NUM_PATHS (NUM_PATHS),
        .PRIO_W    (PRIO_W),
        .WEIGHT_W  (WEIGHT_W),
        .GROUP_ID  (g)
      ) u_grp (
        .clk         (clk),
        .rst_n       (rst_s_n),
        .slot_en     (slot_en),
        .win         (grp_go[g]),
        .path_req    (path_req),
        .path_prio   (prio_q),
        .path_weight (weight_q),
        .grp_req     (grp_req[g]),
        .pick        (grp_pick[g])
      );
    end
  endgenerate

  lss_layer_pick #(.NUM_GROUPS(NUM_GROUPS)) u_layer (
    .ts_req  (ts_req),
    .fc_req  (fc_req),
    .grp_req (grp_req),
    .layer   (layer),
    .grp_win (grp_win)
  );

  // Next grant.
  always_comb begin
    ts_d   = slot_en && (layer == LYR_TSYNC);
    fc_d   = slot_en && (layer == LYR_FCTL);
    path_d = '0;
    if (slot_en) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (grp_go[g]) path_d = path_d | grp_pick[g];
      end
    end
    valid_d = ts_d || fc_d || (|path_d);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      gnt_ts    <= 1'b0;
      gnt_fc    <= 1'b0;
      gnt_path  <= '0;
      gnt_valid <= 1'b0;
    end else begin
      gnt_ts    <= ts_d;
      gnt_fc    <= fc_d;
      gnt_path  <= path_d;
      gnt_valid <= valid_d;
    end
  end

  // R9
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({gnt_path, gnt_fc, gnt_ts}) && (gnt_valid == (|{gnt_path, gnt_fc, gnt_ts})));

  // R1
  tsync_first_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (slot_en && ts_req) |=> (gnt_ts && !gnt_fc && (gnt_path == '0)));

  // R2
  fctl_second_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (slot_en && !ts_req && fc_req) |=> (gnt_fc && !gnt_ts));

  // R3
  path_served_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (slot_en && !ts_req && !fc_req && (|path_req)) |=> ((gnt_path & $past(path_req)) != '0));

  // R8
  no_slot_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!slot_en) |=> !gnt_valid);

  // R7
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    gnt_valid |=> ($stable(prio_q) && $stable(weight_q)));

endmodule

// File: tb/link_slot_sched_test.sv
module link_slot_sched_test;

  localparam int N  = 8;
  localparam int PW = 3;
  localparam int WW = 4;
  localparam int VW = N + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slot_en;
  logic          ts_req, fc_req;
  logic [N-1:0]  path_req;
  logic [N*PW-1:0] cfg_prio;
  logic [N*WW-1:0] cfg_weight;
  logic          gnt_ts, gnt_fc, gnt_valid;
  logic [N-1:0]  gnt_path;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  link_slot_sched #(.NUM_PATHS(N), .PRIO_W(PW), .WEIGHT_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .ts_req(ts_req), .fc_req(fc_req),
    .path_req(path_req), .cfg_prio(cfg_prio), .cfg_weight(cfg_weight),
    .gnt_ts(gnt_ts), .gnt_fc(gnt_fc), .gnt_path(gnt_path), .gnt_valid(gnt_valid)
  );

  localparam logic [VW-1:0] NONE = '0;
  localparam logic [VW-1:0] TS   = VW'(1);
  localparam logic [VW-1:0] FC   = VW'(2);

  function automatic logic [VW-1:0] P(input int i);
    return VW'(1) << (i + 2);
  endfunction

  // Driver: applies one slot's inputs at the falling edge and queues the expectation.
  task automatic slot(input logic se, input logic ts, input logic fc,
                      input logic [N-1:0] rq, input logic [VW-1:0] exp, input string tag);
    @(negedge clk);
    slot_en  = se;
    ts_req   = ts;
    fc_req   = fc;
    path_req = rq;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after each rising edge, away from it.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      logic [VW-1:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {gnt_path, gnt_fc, gnt_ts};
      checks++;
      if (a !== e || gnt_valid !== (|e)) begin
        fails++;
        $display("FAIL %s: actual grant=%b valid=%b expected grant=%b valid=%b",
                 t, a, gnt_valid, e, |e);
      end
    end
  end

  initial begin
    // p0 g0 w1, p1 g1 w1, p2 g2 w2, p3 g2 w1, p4 g3 w1, p5 g2 w3, p6 g7 w0, p7 g7 w1
    cfg_prio   = {3'd7, 3'd7, 3'd2, 3'd3, 3'd2, 3'd2, 3'd1, 3'd0};
    cfg_weight = {4'd1, 4'd0, 4'd3, 4'd1, 4'd1, 4'd2, 4'd1, 4'd1};
    rst_n = 1'b0; slot_en = 1'b0; ts_req = 1'b0; fc_req = 1'b0; path_req = '0;

    // R9: quiet during reset even with requests
    slot(1'b1, 1'b1, 1'b1, 8'hFF, NONE, "R9 reset");
    slot(1'b1, 1'b0, 1'b0, 8'hFF, NONE, "R9 reset");
    slot(1'b0, 1'b0, 1'b0, 8'h00, NONE, "R9 reset");
    @(negedge clk); rst_n = 1'b1;
    exp_q.push_back(NONE); tag_q.push_back("R9 release");
    repeat (4) slot(1'b1, 1'b0, 1'b0, 8'h00, NONE, "R9 idle");

    // R1 / R2 fixed layers
    slot(1'b1, 1'b1, 1'b1, 8'hFF, TS, "R1 tsync over all");
    slot(1'b1, 1'b1, 1'b0, 8'h10, TS, "R1 tsync over path");
    slot(1'b1, 1'b0, 1'b1, 8'hFF, FC, "R2 fctl over paths");

    // R3 group priority and skipping empty groups
    slot(1'b1, 1'b0, 1'b0, 8'b0001_0010, P(1), "R3 group1 beats group3");
    slot(1'b1, 1'b0, 1'b0, 8'b0001_0000, P(4), "R3 empty groups skipped");
    slot(1'b1, 1'b0, 1'b0, 8'b0001_0011, P(0), "R3 group0 first");

    // R4 weights 2 and 1 in group 2
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(2), "R4 wrr");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(2), "R4 wrr");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(3), "R4 wrr");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(2), "R4 wrr");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(2), "R4 wrr");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(3), "R4 wrr");

    // R4 add weight-3 path
    slot(1'b1, 1'b0, 1'b0, 8'b0010_1100, P(5), "R4 wrr w3");
    slot(1'b1, 1'b0, 1'b0, 8'b0010_1100, P(5), "R4 wrr w3");
    slot(1'b1, 1'b0, 1'b0, 8'b0010_1100, P(5), "R4 wrr w3");
    slot(1'b1, 1'b0, 1'b0, 8'b0010_1100, P(2), "R4 wrr wrap");
    slot(1'b1, 1'b0, 1'b0, 8'b0010_1100, P(2), "R4 wrr wrap");
    slot(1'b1, 1'b0, 1'b0, 8'b0010_1100, P(3), "R4 wrr wrap");
    slot(1'b1, 1'b0, 1'b0, 8'b0010_1100, P(5), "R4 wrr wrap");

    // R10 hold across a lost slot, R5 forfeit on dropped request
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(2), "R4 turn leaves idle path");
    slot(1'b1, 1'b1, 1'b0, 8'b0000_1100, TS,   "R1 tsync preempts group");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(2), "R10 turn kept");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(3), "R10 then moves");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(2), "R5 setup");
    slot(1'b1, 1'b0, 1'b0, 8'b0001_0000, P(4), "R5 drop slot");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_1100, P(3), "R5 weight forfeited");

    // R6 weight 0 served as 1
    slot(1'b1, 1'b0, 1'b0, 8'b1100_0000, P(6), "R6 zero weight");
    slot(1'b1, 1'b0, 1'b0, 8'b1100_0000, P(7), "R6 zero weight");
    slot(1'b1, 1'b0, 1'b0, 8'b1100_0000, P(6), "R6 zero weight");

    // R7 configuration deferred while grants stream: move p4 to group 0
    @(negedge clk);
    cfg_prio[4*PW +: PW] = 3'd0;
    slot_en = 1'b1; ts_req = 1'b0; fc_req = 1'b0; path_req = 8'b0001_0010;
    exp_q.push_back(P(1)); tag_q.push_back("R7 held while busy");
    slot(1'b1, 1'b0, 1'b0, 8'b0001_0010, P(1), "R7 held while busy");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_0000, NONE, "R7 gap");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_0000, NONE, "R7 gap");
    slot(1'b1, 1'b0, 1'b0, 8'b0001_0010, P(4), "R7 new group applies");

    // R8 no slot
    slot(1'b0, 1'b0, 1'b0, 8'b0000_0001, NONE, "R8 no slot");
    slot(1'b0, 1'b1, 1'b1, 8'b0000_0001, NONE, "R8 no slot");
    slot(1'b1, 1'b0, 1'b0, 8'b0000_0001, P(0), "R8 slot resumes");

    @(negedge clk);
    slot_en = 1'b0; path_req = '0;
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule